// File: doc/BRIEF.md
# Source-Synchronous Serial Data Transmitter

This block takes a parallel conversion result and shifts it out to a host over one, two or four data lanes. A strobe travels with the data, and each strobe transition marks a valid set of lane bits. The host can therefore capture the word without knowing anything about the block's internal timing. The strobe is derived from one of four sources: the host's own serial clock, the block's internal clock, or that internal clock divided by 2 or by 4. Each bit set is launched either on strobe rising edges only (single data rate) or on both strobe edges (double data rate).

The block runs on its core clock `int_clk`. The undivided internal source toggles once per core cycle, so its strobe period is 2 core cycles. The divided sources have periods of 4 and 8 core cycles. The host serial clock is sampled into the core domain and its edges are detected there.

An 8-bit control register is loaded through a simple write strobe. It selects the source, the lane count and the rate, and it gates the whole transmitter. The settings are captured when a frame is accepted, so a write made during a frame changes only later frames. A frame begins on a start request while the block is idle. The block reports `busy_o` for the length of the frame, and the strobe and all lanes are driven low between frames.

Top module: `sst_tx`

## Requirements
- R1: After reset, `strobe_o`, `lane_o` and `busy_o` are low. The control register is 00h, which leaves the transmitter disabled, so a start request before any write produces no frame.
- R2: Control bits [1:0] must be 11 for a start request to be accepted. With any other value, `busy_o` stays low and the strobe does not move.
- R3: Control bits [7:6] select the strobe source, and every strobe period inside a frame has a fixed length:
  - 01: 2 core cycles.
  - 10: 4 core cycles.
  - 11: 8 core cycles.
  - 00: follows the host serial clock. Each strobe rise appears two `int_clk` rising edges after the host clock rises.
- R4: Control bits [3:2] select the lane count: 11 gives four lanes (`lane_o[3:0]`), 10 gives two lanes (`lane_o[1:0]`), and 00 or 01 gives one lane (`lane_o[0]`). Lanes that are not in use stay low.
- R5: When control bit 4 is 0, bit sets are launched only together with strobe rising edges, and data holds when the strobe falls. When bit 4 is 1, a bit set is launched with every strobe transition, and the first launch of a frame coincides with a rising edge.
- R6: With n lanes and an 18-bit word, each lane carries S = ceil(18/n) bits, MSB first. Lane 0 holds word bits [17:18-S], lane 1 the next S bits below those, and so on. Bit slots past the end of the word are sent as 0.
- R7: The number of strobe pulses (rising edges) in a frame is S at single rate and ceil(S/2) at double rate. This gives 18, 9, 5 at single rate and 9, 5, 3 at double rate for one, two and four lanes.
- R8: `busy_o` rises on the core cycle after a request is accepted. It falls at the first strobe-source edge after the last launch, at which point the strobe and lanes return low.
- R9: A start request that arrives while `busy_o` is high is ignored. Neither the frame in flight nor the cycles after it are affected.
- R10: A control write made during a frame does not change that frame's source, lane count or rate. The new setting governs the next accepted frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| int_clk | input | 1 | Core clock; the internal strobe sources are derived from it |
| rst | input | 1 | Synchronous active-high reset |
| host_sclk | input | 1 | Host serial clock, used as the strobe source when bits [7:6] are 00 |
| cfg_we | input | 1 | Write enable for the control register |
| cfg_wdata | input | 8 | Control register write value |
| start_i | input | 1 | Start-of-frame request |
| data_i | input | DATA_W | Parallel word, captured when a request is accepted |
| lane_o | output | 4 | Serial data lanes |
| strobe_o | output | 1 | Source-synchronous strobe |
| busy_o | output | 1 | High while a frame is in progress |

## Verification
- **Request acceptance.** The request is sampled at one `int_clk` edge, and `busy_o` is checked one cycle later. This is the only result tied to a fixed cycle after the request.
- **Host-clock source.** With source 00, each strobe rise is due exactly two core edges after the host clock rises. The bench records the cycle of every host-clock rise and compares it with the cycle of the matching strobe rise.
- **Internal sources.** For the divided and undivided sources, the phase of the first launch depends on a free-running divider. The bench therefore behaves as a host would: it captures lane values at every strobe transition that belongs to the current rate, measures the spacing between strobe rises, and checks the assembled frame only after `busy_o` drops.
- **Sampling point.** All sampling is done on falling core edges, away from the edges that update the outputs.

// File: rtl/sst_pkg.sv
`timescale 1ns/1ps
package sst_pkg;

  // Number of physical data lanes; the width field encoding below assumes four.
  localparam int LANES = 4;

  // Strobe source codes held in control bits [7:6]
  localparam logic [1:0] SRC_HOST = 2'b00;
  localparam logic [1:0] SRC_INT  = 2'b01;
  localparam logic [1:0] SRC_DIV2 = 2'b10;
  localparam logic [1:0] SRC_DIV4 = 2'b11;

  // Lane count codes held in control bits [3:2]
  localparam logic [1:0] WID_FOUR = 2'b11;
  localparam logic [1:0] WID_TWO  = 2'b10;

  // Transmitter enable value for control bits [1:0]
  localparam logic [1:0] MODE_ON  = 2'b11;

  // Stored control fields (bit 5 of the written byte carries no function)
  typedef struct packed {
    logic [1:0] src;
    logic       ddr;
    logic [1:0] width;
    logic [1:0] mode;
  } ctl_t;

endpackage

// File: rtl/sst_clk_sel.sv
`timescale 1ns/1ps
// Strobe-source generator: samples the host clock, runs the internal divider
// and reports rising/falling edges of the selected source, one flag per cycle.
module sst_clk_sel #(
  parameter int DIV_STAGES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_sclk_i,
  input  logic [1:0] sel_i,
  output logic       rise_o,
  output logic       fall_o
);
  localparam int NSRC = DIV_STAGES + 1;

  logic [DIV_STAGES-1:0] div_q;
  logic                  host_q;
  logic [NSRC-1:0]       lvl;
  logic [NSRC-1:0]       lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      host_q <= 1'b0;
      lvl_q  <= '0;
    end else begin
      div_q  <= div_q + 1'b1;
      host_q <= host_sclk_i;
      lvl_q  <= lvl;
    end
  end

  // Source 0 is the sampled host clock; source g+1 is divider bit g
  assign lvl[0] = host_q;
  for (genvar g = 0; g < DIV_STAGES; g++) begin : g_div
    assign lvl[g+1] = div_q[g];
  end

  // All sources keep their own history, so changing the selection makes no false edge
  assign rise_o = lvl[sel_i]  & ~lvl_q[sel_i];
  assign fall_o = ~lvl[sel_i] &  lvl_q[sel_i];

endmodule

// File: rtl/sst_lane_map.sv
`timescale 1ns/1ps
// Computes the bit set for launch slot idx_i: lane l carries word position
// l*S + idx (MSB first), zero past the end of the word or on unused lanes.
module sst_lane_map
  import sst_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int IDX_W  = 5
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [1:0]        width_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [LANES-1:0]  bits_o,
  output logic [IDX_W-1:0]  slots_o
);
  localparam int SL1 = DATA_W;
  localparam int SL2 = (DATA_W + 1) / 2;
  localparam int SL4 = (DATA_W + 3) / 4;

  int n_act;
  int slice;

  always_comb begin
    case (width_i)
      WID_FOUR: begin n_act = 4; slice = SL4; end
      WID_TWO:  begin n_act = 2; slice = SL2; end
      default:  begin n_act = 1; slice = SL1; end
    endcase
  end

  assign slots_o = IDX_W'(slice);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic              bit_l;
    logic [DATA_W-1:0] shifted;
    int                pos;
    always_comb begin
      pos     = l * slice + int'(idx_i);
      shifted = '0;
      bit_l   = 1'b0;
      if (l < n_act && pos < DATA_W) begin
        shifted = word_i >> (DATA_W - 1 - pos);
        bit_l   = shifted[0];
      end
    end
    assign bits_o[l] = bit_l;
  end

endmodule

// File: rtl/sst_tx.sv
`timescale 1ns/1ps
// Source-synchronous transmitter top: control register, frame sequencer,
// registered strobe and lane outputs.
module sst_tx #(
  parameter int DATA_W = 18
) (
  input  logic                      int_clk,
  input  logic                      rst,
  input  logic                      host_sclk,
  input  logic                      cfg_we,
  input  logic [7:0]                cfg_wdata,
  input  logic                      start_i,
  input  logic [DATA_W-1:0]         data_i,
  output logic [sst_pkg::LANES-1:0] lane_o,
  output logic                      strobe_o,
  output logic                      busy_o
);
  import sst_pkg::*;

  localparam int IDX_W = $clog2(DATA_W + 1);

  ctl_t              ctl_q;
  logic [1:0]        run_src_q;
  logic [1:0]        run_width_q;
  logic              run_ddr_q;
  logic [DATA_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  logic              busy_q;
  logic              started_q;
  logic              last_q;
  logic              strobe_q;
  logic [LANES-1:0]  lane_q;

  logic              oc_rise;
  logic              oc_fall;
  logic [LANES-1:0]  map_bits;
  logic [IDX_W-1:0]  slots;
  logic              launch;
  logic              close_frame;
  logic              cfg_spare_unused;

  assign cfg_spare_unused = cfg_wdata[5];

  sst_clk_sel #(.DIV_STAGES(3)) u_clk (
    .clk         (int_clk),
    .rst         (rst),
    .host_sclk_i (host_sclk),
    .sel_i       (run_src_q),
    .rise_o      (oc_rise),
    .fall_o      (oc_fall)
  );

  sst_lane_map #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_map (
    .word_i  (word_q),
    .width_i (run_width_q),
    .idx_i   (idx_q),
    .bits_o  (map_bits),
    .slots_o (slots)
  );

  // First launch waits for a rising edge; later ones use falls too at double rate
  assign launch      = busy_q & ~last_q &
                       (started_q ? (oc_rise | (oc_fall & run_ddr_q)) : oc_rise);
  assign close_frame = busy_q & last_q & (oc_rise | oc_fall);

  always_ff @(posedge int_clk) begin
    if (rst) begin
      ctl_q       <= '0;
      run_src_q   <= SRC_HOST;
      run_width_q <= '0;
      run_ddr_q   <= 1'b0;
      word_q      <= '0;
      idx_q       <= '0;
      busy_q      <= 1'b0;
      started_q   <= 1'b0;
      last_q      <= 1'b0;
      strobe_q    <= 1'b0;
      lane_q      <= '0;
    end else begin
      if (cfg_we) begin
        ctl_q <= '{src: cfg_wdata[7:6], ddr: cfg_wdata[4],
                   width: cfg_wdata[3:2], mode: cfg_wdata[1:0]};
      end
      if (!busy_q) begin
        if (start_i && ctl_q.mode == MODE_ON) begin
          busy_q      <= 1'b1;
          run_src_q   <= ctl_q.src;
          run_width_q <= ctl_q.width;
          run_ddr_q   <= ctl_q.ddr;
          word_q      <= data_i;
          idx_q       <= '0;
          started_q   <= 1'b0;
          last_q      <= 1'b0;
        end
      end else if (close_frame) begin
        busy_q   <= 1'b0;
        strobe_q <= 1'b0;
        lane_q   <= '0;
      end else begin
        if (oc_rise) strobe_q <= 1'b1;
        if (oc_fall) strobe_q <= 1'b0;
        if (launch) begin
          lane_q    <= map_bits;
          idx_q     <= idx_q + 1'b1;
          started_q <= 1'b1;
          if (idx_q + 1'b1 == slots) last_q <= 1'b1;
        end
      end
    end
  end

  assign lane_o   = lane_q;
  assign strobe_o = strobe_q;
  assign busy_o   = busy_q;

endmodule

// File: rtl/sst_tx_chk.sv
`timescale 1ns/1ps
// Protocol checker attached to sst_tx.
module sst_tx_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             strobe,
  input logic [LANES-1:0] lanes,
  input logic [1:0]       cfg_mode,
  input logic             run_ddr,
  input logic [1:0]       run_width
);

  AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!strobe && lanes == '0));  // R8

  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && cfg_mode != 2'b11) |=> !busy);  // R2

  AST_START_FROM_REQUEST: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));  // R2

  AST_LANES_MOVE_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    (busy && !$stable(lanes)) |-> !$stable(strobe));  // R5

  AST_SDR_HOLD_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (busy && !run_ddr && $fell(strobe)) |-> $stable(lanes));  // R5

  AST_ONE_LANE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !run_width[1] |-> lanes[LANES-1:1] == '0);  // R4

  AST_TWO_LANE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (run_width == 2'b10) |-> lanes[LANES-1:2] == '0);  // R4

endmodule

bind sst_tx sst_tx_chk #(.LANES(sst_pkg::LANES)) u_chk (
  .clk       (int_clk),
  .rst       (rst),
  .start     (start_i),
  .busy      (busy_o),
  .strobe    (strobe_o),
  .lanes     (lane_o),
  .cfg_mode  (ctl_q.mode),
  .run_ddr   (run_ddr_q),
  .run_width (run_width_q)
);

// File: tb/sst_tx_tb.sv
`timescale 1ns/1ps
module sst_tx_tb;
  localparam int DW = 18;
  localparam int NV = 9;
  // {control byte, data word}
  localparam logic [25:0] VEC [0:NV-1] = '{
    {8'h43, 18'h2A5C3},   // internal, one lane, SDR
    {8'h53, 18'h3F00F},   // internal, one lane, DDR
    {8'h8B, 18'h1B6D2},   // /2, two lanes, SDR
    {8'h9B, 18'h0C3A5},   // /2, two lanes, DDR
    {8'hCF, 18'h3FFFF},   // /4, four lanes, SDR (padding)
    {8'hDF, 18'h25A96},   // /4, four lanes, DDR
    {8'h0F, 18'h1E4B7},   // host clock, four lanes, SDR
    {8'h1B, 18'h35C1A},   // host clock, two lanes, DDR
    {8'h47, 18'h00001}    // width code 01 acts as one lane
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_sclk = 1'b0;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic          start = 1'b0;
  logic [DW-1:0] din = '0;
  logic [3:0]    dout;
  logic          strobe;
  logic          busy;

  int     n_chk = 0;
  int     n_bad = 0;
  longint cyc = 0;
  longint hrise_cyc = 0;
  int     hcnt = 0;

  sst_tx #(.DATA_W(DW)) u_dut (
    .int_clk(clk), .rst(rst), .host_sclk(host_sclk), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .start_i(start), .data_i(din),
    .lane_o(dout), .strobe_o(strobe), .busy_o(busy)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Host serial clock: period of 6 core cycles, changes 1 ns after a core edge
  always @(posedge clk) begin
    #1;
    hcnt = hcnt + 1;
    if (hcnt == 3) begin
      hcnt = 0;
      host_sclk = ~host_sclk;
      if (host_sclk) hrise_cyc = cyc;
    end
  end

  // ---------------- host-side capture monitor ----------------
  logic       st_prev = 1'b0;
  int         pulses, nlaunch, per_min, per_max, lat_bad;
  longint     last_rise;
  logic       extra_lane, first_on_rise, mon_ddr, mon_ext;
  int         mon_n;
  logic [3:0] got [0:31];

  function automatic int lanes_of(logic [7:0] c);
    if (c[3:2] == 2'b11) return 4;
    if (c[3:2] == 2'b10) return 2;
    return 1;
  endfunction

  function automatic int period_of(logic [7:0] c);
    case (c[7:6])
      2'b00: return 6;
      2'b01: return 2;
      2'b10: return 4;
      default: return 8;
    endcase
  endfunction

  always @(negedge clk) begin
    if (strobe != st_prev) begin
      if (strobe) begin
        pulses = pulses + 1;
        if (pulses > 1) begin
          if (int'(cyc - last_rise) < per_min) per_min = int'(cyc - last_rise);
          if (int'(cyc - last_rise) > per_max) per_max = int'(cyc - last_rise);
        end
        last_rise = cyc;
        if (mon_ext && (cyc - hrise_cyc) != 2) lat_bad = lat_bad + 1;
      end
      if (busy && (strobe || mon_ddr)) begin
        if (nlaunch == 0) first_on_rise = strobe;
        if (nlaunch < 32) got[nlaunch] = dout;
        nlaunch = nlaunch + 1;
      end
    end
    if (busy && ((dout >> mon_n) != 4'd0)) extra_lane = 1'b1;
    st_prev = strobe;
  end

  // ---------------- helpers ----------------
  logic [7:0]    exp_ctl;
  logic [DW-1:0] exp_data;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon(input logic [7:0] c, input logic [DW-1:0] d);
    exp_ctl = c; exp_data = d;
    pulses = 0; nlaunch = 0; per_min = 1000; per_max = 0; lat_bad = 0;
    extra_lane = 1'b0; first_on_rise = 1'b0;
    mon_ddr = c[4]; mon_ext = (c[7:6] == 2'b00); mon_n = lanes_of(c);
    for (int i = 0; i < 32; i++) got[i] = '0;
  endtask

  task automatic set_cfg(input logic [7:0] v);
    @(posedge clk); #1 cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic pulse_start(input logic [DW-1:0] d);
    @(posedge clk); #1 start = 1'b1; din = d;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic begin_frame(input logic [7:0] c, input logic [DW-1:0] d);
    clear_mon(c, d);
    pulse_start(d);
    chk(busy == 1'b1, "R8", "busy one cycle after accept", busy, 1);
  endtask

  task automatic end_frame(input string ctx);
    int n, s, exp_p, bad;
    logic [3:0] e;
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1;
      if (!busy) break;
    end
    @(posedge clk); #1;
    n = lanes_of(exp_ctl);
    s = (DW + n - 1) / n;
    exp_p = exp_ctl[4] ? (s + 1) / 2 : s;
    chk(pulses == exp_p, "R7", {ctx, " strobe pulses"}, pulses, exp_p);
    chk(nlaunch == s, "R6", {ctx, " launch count"}, nlaunch, s);
    bad = 0;
    for (int k = 0; k < 32; k++) begin
      e = '0;
      for (int l = 0; l < 4; l++)
        if (k < s && l < n && (l * s + k) < DW) e[l] = exp_data[DW - 1 - (l * s + k)];
      if (got[k] !== e) bad++;
    end
    chk(bad == 0, "R6", {ctx, " lane bit mismatches"}, bad, 0);
    chk(first_on_rise == 1'b1, "R5", {ctx, " first launch on rising strobe"}, first_on_rise, 1);
    chk(extra_lane == 1'b0, "R4", {ctx, " unused lane activity"}, extra_lane, 0);
    if (exp_p > 1) begin
      chk(per_min == period_of(exp_ctl) && per_max == period_of(exp_ctl), "R3",
          {ctx, " strobe period (max shown)"}, per_max, period_of(exp_ctl));
    end
    if (exp_ctl[7:6] == 2'b00)
      chk(lat_bad == 0, "R3", {ctx, " host-clock to strobe latency errors"}, lat_bad, 0);
    chk(busy == 1'b0 && strobe == 1'b0 && dout == 4'd0, "R8", {ctx, " idle lines after frame"},
        {busy, strobe, dout}, 0);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int hi;
    clear_mon(8'h00, '0);
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    // R1: reset state
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(strobe == 1'b0, "R1", "strobe after reset", strobe, 0);
    chk(dout == 4'd0, "R1", "lanes after reset", dout, 0);

    // R1/R2: register resets disabled, request ignored
    clear_mon(8'h00, '0);
    pulse_start(18'h12345);
    hi = 0;
    for (int i = 0; i < 30; i++) begin @(posedge clk); #1; if (busy) hi++; end
    chk(hi == 0 && pulses == 0, "R1", "frame from reset register", hi + pulses, 0);

    // R2: enable field 10 is not the enable code
    set_cfg(8'h42);
    clear_mon(8'h42, '0);
    pulse_start(18'h0F0F0);
    hi = 0;
    for (int i = 0; i < 30; i++) begin @(posedge clk); #1; if (busy) hi++; end
    chk(hi == 0 && pulses == 0, "R2", "frame with mode bits 10", hi + pulses, 0);

    // Vector table: R3..R8 across source, width and rate
    for (int v = 0; v < NV; v++) begin
      set_cfg(VEC[v][25:18]);
      begin_frame(VEC[v][25:18], VEC[v][17:0]);
      end_frame($sformatf("vec%0d", v));
    end

    // R9: request during a frame is ignored
    set_cfg(8'h43);
    begin_frame(8'h43, 18'h2D2D2);
    repeat (10) @(posedge clk);
    #1 start = 1'b1; din = 18'h15555;
    @(posedge clk); #1 start = 1'b0;
    end_frame("R9 frame");
    hi = 0;
    for (int i = 0; i < 40; i++) begin @(posedge clk); #1; if (busy) hi++; end
    chk(hi == 0, "R9", "busy cycles after ignored request", hi, 0);

    // R10: mid-frame control write does not alter the running frame
    set_cfg(8'hCF);
    begin_frame(8'hCF, 18'h3A5C7);
    repeat (6) @(posedge clk);
    set_cfg(8'h43);
    end_frame("R10 old mode");
    chk(pulses == 5, "R10", "pulses of frame with mid-frame write", pulses, 5);
    begin_frame(8'h43, 18'h0BEEF);
    end_frame("R10 new mode");
    chk(pulses == 18, "R10", "pulses of next frame", pulses, 18);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule